// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block stores a small word one bit at a time. A single data bit and a binary bit address come in, and the addressed storage bit takes the data. All stored bits are driven in parallel on the output at all times. Two active-high control inputs pick the operating mode. One is a write inhibit and the other is a clear/steer control. Together they give four modes:

- **Addressed write:** the addressed bit takes the data.
- **Hold:** nothing changes.
- **Clear:** every bit goes to zero.
- **Demultiplex:** the addressed output carries the data bit and every other output is zero.

Storage is edge-sampled on the block clock. Every mode takes effect at the next rising edge after its inputs are presented. A synchronous active-low reset empties the store. The word width follows from the address width, one output bit per address value.

Top module: `bit_latch_demux`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every bit of `q` is 0 after that edge.
- R2: With `wr_hold`=0 and `clr_steer`=0 at an edge, bit `q[addr]` equals `din` after the edge. Address value k selects output bit k. The other bits of `q` keep their values.
- R3: With `wr_hold`=1 and `clr_steer`=0 at an edge, `q` does not change, whatever `din` and `addr` are.
- R4: With `wr_hold`=1 and `clr_steer`=1 at an edge, every bit of `q` is 0 after the edge.
- R5: With `clr_steer`=1 and `wr_hold`=0 at an edge, `q[addr]` equals `din` after the edge and every other bit is 0. As a result, at most one bit of `q` is 1.
- R6: When the block leaves demultiplex mode into hold, `q` keeps the pattern written by the last demultiplex edge.
- R7: `q` is a registered output. It changes only at rising clock edges, one edge after the inputs that cause the change are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Serial data bit |
| addr | input | ADDR_W | Binary index of the target bit |
| wr_hold | input | 1 | Write inhibit, active high |
| clr_steer | input | 1 | Clear (with `wr_hold`=1) or demultiplex (with `wr_hold`=0), active high |
| q | output | 2**ADDR_W | Stored bits, presented in parallel |

## Verification
Every address is driven with both data values in each of the four modes. The hold steps flip `din` and move `addr`, so a write that leaks through while inhibited would show on `q`. Write steps that set a second bit next to an existing one tell a true single-bit update apart from a whole-word overwrite. The step from demultiplex into hold, and the clear and reset steps taken with a populated store, show that each mode transition leaves exactly the expected pattern.

// File: rtl/bit_latch_pkg.sv
// Package: shared types for the addressable bit latch.
// Assumes: nothing beyond IEEE 1800-2017.
package bit_latch_pkg;

    // Operating mode decoded from the two control inputs.
    typedef enum logic [1:0] {
        MODE_WRITE = 2'b00,
        MODE_HOLD  = 2'b01,
        MODE_DEMUX = 2'b10,
        MODE_CLEAR = 2'b11
    } latch_mode_t;

endpackage

// File: rtl/bit_latch_mode_dec.sv
// Module: turns the write-inhibit and clear/steer inputs into one mode value.
// Assumes: both inputs are active high; every combination maps to exactly one mode.
module bit_latch_mode_dec
    import bit_latch_pkg::*;
(
    input  logic        wr_hold,
    input  logic        clr_steer,
    output latch_mode_t mode
);

    // Decode the two controls into a mode with no overlap between cases.
    always_comb begin
        unique case ({clr_steer, wr_hold})
            2'b00:   mode = MODE_WRITE;
            2'b01:   mode = MODE_HOLD;
            2'b10:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end

endmodule

// File: rtl/bit_latch_addr_dec.sv
// Module: one-hot decode of the binary bit address.
// Assumes: N_BITS equals 2**ADDR_W, so every address value names a real bit.
module bit_latch_addr_dec #(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_BITS-1:0] sel
);

    // One comparator per output bit.
    for (genvar gi = 0; gi < N_BITS; gi++) begin : g_sel
        assign sel[gi] = (addr == ADDR_W'(gi));
    end

endmodule

// File: rtl/bit_latch_cell.sv
// Module: one storage bit with its mode-dependent next-state logic.
// Assumes: sel is high for this bit only when the address names it.
module bit_latch_cell
    import bit_latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  latch_mode_t mode,
    input  logic        sel,
    input  logic        din,
    output logic        q_bit
);

    logic nxt;

    // Next value of this bit for the current mode.
    always_comb begin
        unique case (mode)
            MODE_WRITE: nxt = sel ? din : q_bit;
            MODE_HOLD:  nxt = q_bit;
            MODE_DEMUX: nxt = sel & din;
            default:    nxt = 1'b0;
        endcase
    end

    // Storage flop with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_bit <= 1'b0;
        else        q_bit <= nxt;
    end

endmodule

// File: rtl/bit_latch_demux.sv
// Module: top of the addressable bit latch with clear and demultiplex modes.
// Assumes: inputs are synchronous to clk; q width is 2**ADDR_W.
module bit_latch_demux
    import bit_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_hold,
    input  logic              clr_steer,
    output logic [N_BITS-1:0] q
);

    latch_mode_t       mode;
    logic [N_BITS-1:0] sel;

    // Mode selection shared by all bits.
    bit_latch_mode_dec u_mode (
        .wr_hold   (wr_hold),
        .clr_steer (clr_steer),
        .mode      (mode)
    );

    // Address decode shared by all bits.
    bit_latch_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .addr (addr),
        .sel  (sel)
    );

    // One storage cell per output bit.
    for (genvar gi = 0; gi < N_BITS; gi++) begin : g_cell
        bit_latch_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode),
            .sel   (sel[gi]),
            .din   (din),
            .q_bit (q[gi])
        );
    end

endmodule

// File: rtl/bit_latch_demux_chk.sv
// Module: property checker for bit_latch_demux, attached by bind.
// Assumes: every check is judged one edge after the inputs that cause it.
module bit_latch_demux_chk #(
    parameter int ADDR_W = 3,
    localparam int N_BITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_hold,
    input  logic              clr_steer,
    input  logic [N_BITS-1:0] q
);

    // R2: the addressed bit takes the data bit.
    a_r2_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hold && !clr_steer) |=> (q[$past(addr)] == $past(din)));

    // R2: the bits that are not addressed keep their values.
    a_r2_write_others: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hold && !clr_steer) |=>
        (((q ^ $past(q)) & ~(N_BITS'(1) << $past(addr))) == '0));

    // R3: hold leaves the store unchanged.
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && !clr_steer) |=> $stable(q));

    // R4: clear empties the store.
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hold && clr_steer) |=> (q == '0));

    // R5: demultiplex puts the data bit on the addressed output only.
    a_r5_demux_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hold && clr_steer) |=> (q == (N_BITS'($past(din)) << $past(addr))));

    // R5: demultiplex never drives more than one output high.
    a_r5_demux_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hold && clr_steer) |=> $onehot0(q));

endmodule

bind bit_latch_demux bit_latch_demux_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .addr      (addr),
    .wr_hold   (wr_hold),
    .clr_steer (clr_steer),
    .q         (q)
);

// File: tb/bit_latch_demux_bench.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected words into a queue; the monitor pops and compares them after each edge.
module bit_latch_demux_bench;

    localparam int ADDR_W = 3;
    localparam int N_BITS = 1 << ADDR_W;

    typedef struct {
        logic [N_BITS-1:0] exp;
        string             tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_hold = 1'b1;
    logic              clr_steer = 1'b0;
    logic [N_BITS-1:0] q;

    sb_item_t          sb[$];
    sb_item_t          item;
    logic [N_BITS-1:0] model = '0;
    int                checks = 0;
    int                fails = 0;
    bit                done = 1'b0;

    bit_latch_demux #(.ADDR_W(ADDR_W)) u_bit_latch_demux (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .addr      (addr),
        .wr_hold   (wr_hold),
        .clr_steer (clr_steer),
        .q         (q)
    );

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    // Drive one cycle of inputs and push the word expected after the next edge.
    task automatic step(input logic rst_v, input logic d, input int a,
                        input logic h, input logic c, input string tag);
        sb_item_t it;
        @(negedge clk);
        rst_n = rst_v; din = d; addr = ADDR_W'(a); wr_hold = h; clr_steer = c;
        if (!rst_v)         model = '0;
        else if (!h && !c)  model[a] = d;
        else if (h && c)    model = '0;
        else if (!h && c)   model = N_BITS'(d) << a;
        it.exp = model;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compare q with the oldest expected word just after each edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item = sb.pop_front();
            checks++;
            if (q !== item.exp) begin
                fails++;
                $display("FAIL %s q=%b expected=%b", item.tag, q, item.exp);
            end
        end
    end

    // Stimulus over every mode, address and data value.
    initial begin
        step(0, 0, 0, 1, 0, "R1 reset");
        step(0, 1, 5, 0, 0, "R1 reset with write inputs");
        for (int a = 0; a < N_BITS; a++) begin
            for (int d = 0; d < 2; d++) begin
                // Seed neighbours so single-bit updates are visible (R2).
                step(1, 1, (a + 3) % N_BITS, 0, 0, "R2 write neighbour");
                step(1, d[0], a, 0, 0, "R2 write addressed bit");
                step(1, ~d[0], (a + 1) % N_BITS, 1, 0, "R3 hold ignores din/addr");
                step(1, ~d[0], a, 1, 0, "R3 hold ignores addressed din");
                step(1, d[0], a, 0, 1, "R5 demux addressed output");
                step(1, ~d[0], (a + 5) % N_BITS, 1, 0, "R6 hold after demux release");
                step(1, 1, a, 0, 0, "R2 write after demux");
                step(1, 1, (a + 2) % N_BITS, 0, 0, "R2 write second bit");
                step(1, d[0], a, 1, 1, "R4 clear all");
                step(1, 1, a, 0, 0, "R7 write after clear");
            end
        end
        // Demux steered across all addresses back to back (R5).
        for (int a = 0; a < N_BITS; a++)
            step(1, 1, a, 0, 1, "R5 demux sweep");
        // Reset with a populated store (R1).
        step(1, 1, 7, 0, 0, "R2 populate before reset");
        step(0, 1, 2, 0, 0, "R1 reset clears populated store");
        step(1, 0, 0, 1, 0, "R3 hold after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired q=%b expected=done", q);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule